// File: doc/BRIEF.md
# Entropy Stream Health Checker

This block judges the statistical quality of a raw random bit stream before the bits are trusted. After a `start` pulse it collects a window of `sample_len` bits, one per accepted handshake. Over that window it counts the ones. It sorts every run of equal bits by length into six bins (1, 2, 3, 4, 5, and 6-or-longer), with separate bins for runs of zeros and runs of ones. It also records the longest run.

When the window is complete, every count is compared with an acceptance band, and an externally measured oscillator frequency count is compared with its own window. A band is given as a maximum and a range, and its lower bound is the maximum minus the range. A failing window is discarded and a fresh one is collected, up to `retry_limit` more times. After the last window the block pulses `done` and holds the verdict flags until the next `start`.

The bit input follows valid/ready rules. A bit moves only in a cycle where `bit_valid` and `bit_ready` are both high. A producer holds `bit_data` with `bit_valid` until it sees `bit_ready`. The block drops `bit_ready` whenever it is not collecting a window, which is how it applies back-pressure. Configuration inputs are plain levels and must stay stable from `start` until `done`.

Top module: `ent_health_chk`

## Requirements
- R1: A bit is taken only in a cycle with `bit_valid` and `bit_ready` both high. `bit_ready` is high only while a window is being collected, from the cycle after an idle `start` until `sample_len` bits have been taken, and is low in idle and while a window is judged.
- R2: The monobit test counts the ones in a window and passes when the count lies within [`mono_max` - `mono_rng`, `mono_max`], both bounds included.
- R3: A run closes when the bit value changes or when the window ends. A closed run of length L adds one to bin index min(L,6)-1 of its own polarity. Both polarity counts of bin index b are checked against [`run_max[b]` - `run_rng[b]`, `run_max[b]`].
- R4: A band with maximum 0 and range 0 is disabled and always passes. A range larger than the maximum gives a lower bound of 0.
- R5: `long_run_fail` is set when a run in the final window is longer than `long_max`. A run exactly `long_max` long is accepted.
- R6: `freq_fail` is set when `freq_count`, sampled while the final window is judged, is below `freq_min` or above `freq_max`. Both bounds are included in the accepted window.
- R7: A window that fails any test is followed by a fresh window with cleared counts, up to `retry_limit` extra windows. Only the last window's verdict is reported, so a retry that passes gives `pass`.
- R8: With `self_test_off` = 1 the monobit, run-length and long-run tests are ignored, so `stat_fail` and `long_run_fail` stay 0. The frequency test still applies.
- R9: `done` is a one-cycle pulse on the third rising clock edge after the final window's last bit is taken. `pass`, `stat_fail`, `freq_fail` and `long_run_fail` update with it and hold until the next idle `start`, which clears all four. `pass` is 1 exactly when the other three are 0. `stat_fail` means a monobit or run-length band failed.
- R10: After reset `done`, `pass`, all fail flags and `bit_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a check; acted on only when idle |
| self_test_off | input | 1 | 1 bypasses the statistical tests |
| sample_len | input | CNT_W | Bits per window (values 0 and 1 both mean one bit) |
| retry_limit | input | RTY_W | Extra windows allowed after a failure |
| mono_max | input | CNT_W | Monobit band maximum |
| mono_rng | input | CNT_W | Monobit band range |
| run_max | input | RUN_BINS x CNT_W | Per-bin run band maximum |
| run_rng | input | RUN_BINS x CNT_W | Per-bin run band range |
| long_max | input | LR_W | Longest allowed run |
| freq_count | input | FRQ_W | Measured oscillator frequency count |
| freq_min | input | FRQ_W | Lowest accepted frequency count |
| freq_max | input | FRQ_W | Highest accepted frequency count |
| bit_valid | input | 1 | Entropy bit offered |
| bit_ready | output | 1 | Block accepts a bit this cycle |
| bit_data | input | 1 | Entropy bit value |
| done | output | 1 | One-cycle verdict pulse |
| pass | output | 1 | Sticky: final window passed |
| stat_fail | output | 1 | Sticky: monobit or run band failed |
| freq_fail | output | 1 | Sticky: frequency count outside its window |
| long_run_fail | output | 1 | Sticky: a run exceeded the long-run limit |

## Verification
The last bit of a window is taken on a rising edge. The final run is closed on the next edge, and the window is judged on the edge after that. `done` and the verdict flags therefore appear on the third rising edge after the last handshake, and a retry window opens `bit_ready` at that same point. The bench drives and samples on falling edges. Right after the last handshake it polls `done` on a fixed sequence of falling edges and requires the pulse exactly two falling edges later, for one cycle only. It also counts accepted bits to confirm how many windows were collected, and checks that the flags are cleared one edge after `start`.

// File: rtl/ehc_pkg.sv
package ehc_pkg;

  localparam int unsigned EHC_CNT_W    = 16;
  localparam int unsigned EHC_RUN_BINS = 6;
  localparam int unsigned EHC_LR_W     = 8;
  localparam int unsigned EHC_FRQ_W    = 24;
  localparam int unsigned EHC_RTY_W    = 4;

  // Recommended configuration values.
  localparam int unsigned EHC_DEF_SAMPLE = 1024;
  localparam int unsigned EHC_DEF_RETRY  = 2;
  localparam int unsigned EHC_DEF_LONG   = 32;
  localparam int unsigned EHC_DEF_FMIN   = 30000;
  localparam int unsigned EHC_DEF_FMAX   = 75000;

  typedef enum logic [1:0] {
    EHC_IDLE,
    EHC_SAMPLE,
    EHC_FLUSH,
    EHC_EVAL
  } ehc_state_t;

  // Band test: max and range both zero disables; lower bound clamps at zero.
  function automatic logic band_pass(input logic [31:0] cnt,
                                     input logic [31:0] hi,
                                     input logic [31:0] rng);
    logic [31:0] lo;
    if (hi == 32'd0 && rng == 32'd0) return 1'b1;
    lo = (rng > hi) ? 32'd0 : (hi - rng);
    return (cnt >= lo) && (cnt <= hi);
  endfunction

endpackage

// File: rtl/ehc_run_tracker.sv
module ehc_run_tracker #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             bit_in,
  input  logic             flush,
  output logic             close_vld,
  output logic             close_val,
  output logic [CNT_W-1:0] close_len,
  output logic [CNT_W-1:0] longest
);

  localparam logic [CNT_W-1:0] LEN_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] LEN_TOP = '1;

  logic             cur_val_q;
  logic [CNT_W-1:0] cur_len_q;
  logic             have_run;
  logic             same_val;

  assign have_run  = (cur_len_q != '0);
  assign same_val  = (bit_in == cur_val_q);
  assign close_vld = have_run && ((take && !same_val) || flush);
  assign close_val = cur_val_q;
  assign close_len = cur_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_val_q <= 1'b0;
      cur_len_q <= '0;
    end else if (clear || flush) begin
      cur_val_q <= 1'b0;
      cur_len_q <= '0;
    end else if (take) begin
      cur_val_q <= bit_in;
      if (have_run && same_val) begin
        if (cur_len_q != LEN_TOP) cur_len_q <= cur_len_q + LEN_ONE;
      end else begin
        cur_len_q <= LEN_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      longest <= '0;
    end else if (clear) begin
      longest <= '0;
    end else if (close_vld && (close_len > longest)) begin
      longest <= close_len;
    end
  end

endmodule

// File: rtl/ehc_tally.sv
module ehc_tally #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned RUN_BINS = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clear,
  input  logic                               take,
  input  logic                               bit_in,
  input  logic                               close_vld,
  input  logic                               close_val,
  input  logic [CNT_W-1:0]                   close_len,
  output logic [CNT_W-1:0]                   ones_cnt,
  output logic [RUN_BINS-1:0][CNT_W-1:0]     zero_runs,
  output logic [RUN_BINS-1:0][CNT_W-1:0]     one_runs
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP  = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_cnt <= '0;
    end else if (clear) begin
      ones_cnt <= '0;
    end else if (take && bit_in && ones_cnt != TOP) begin
      ones_cnt <= ones_cnt + STEP;
    end
  end

  for (genvar b = 0; b < RUN_BINS; b++) begin : g_bin
    logic hit;
    if (b == RUN_BINS - 1) begin : g_tail
      assign hit = (close_len >= CNT_W'(RUN_BINS));
    end else begin : g_exact
      assign hit = (close_len == CNT_W'(b + 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        zero_runs[b] <= '0;
        one_runs[b]  <= '0;
      end else if (clear) begin
        zero_runs[b] <= '0;
        one_runs[b]  <= '0;
      end else if (close_vld && hit) begin
        if (!close_val && zero_runs[b] != TOP) zero_runs[b] <= zero_runs[b] + STEP;
        if (close_val && one_runs[b] != TOP)   one_runs[b]  <= one_runs[b] + STEP;
      end
    end
  end

endmodule

// File: rtl/ehc_verdict.sv
module ehc_verdict
  import ehc_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned RUN_BINS = 6,
  parameter int unsigned LR_W     = 8,
  parameter int unsigned FRQ_W    = 24
) (
  input  logic                           self_test_off,
  input  logic [CNT_W-1:0]               ones_cnt,
  input  logic [RUN_BINS-1:0][CNT_W-1:0] zero_runs,
  input  logic [RUN_BINS-1:0][CNT_W-1:0] one_runs,
  input  logic [CNT_W-1:0]               longest,
  input  logic [CNT_W-1:0]               mono_max,
  input  logic [CNT_W-1:0]               mono_rng,
  input  logic [RUN_BINS-1:0][CNT_W-1:0] run_max,
  input  logic [RUN_BINS-1:0][CNT_W-1:0] run_rng,
  input  logic [LR_W-1:0]                long_max,
  input  logic [FRQ_W-1:0]               freq_count,
  input  logic [FRQ_W-1:0]               freq_min,
  input  logic [FRQ_W-1:0]               freq_max,
  output logic                           stat_bad,
  output logic                           long_bad,
  output logic                           freq_bad
);

  logic [RUN_BINS-1:0] bin_bad;
  logic                mono_bad;

  for (genvar b = 0; b < RUN_BINS; b++) begin : g_band
    assign bin_bad[b] =
      !band_pass(32'(zero_runs[b]), 32'(run_max[b]), 32'(run_rng[b])) ||
      !band_pass(32'(one_runs[b]),  32'(run_max[b]), 32'(run_rng[b]));
  end

  assign mono_bad = !band_pass(32'(ones_cnt), 32'(mono_max), 32'(mono_rng));

  assign stat_bad = !self_test_off && (mono_bad || (|bin_bad));
  assign long_bad = !self_test_off && (32'(longest) > 32'(long_max));
  assign freq_bad = (freq_count < freq_min) || (freq_count > freq_max);

endmodule

// File: rtl/ent_health_chk.sv
module ent_health_chk
  import ehc_pkg::*;
#(
  parameter int unsigned CNT_W    = EHC_CNT_W,
  parameter int unsigned RUN_BINS = EHC_RUN_BINS,
  parameter int unsigned LR_W     = EHC_LR_W,
  parameter int unsigned FRQ_W    = EHC_FRQ_W,
  parameter int unsigned RTY_W    = EHC_RTY_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           self_test_off,
  input  logic [CNT_W-1:0]               sample_len,
  input  logic [RTY_W-1:0]               retry_limit,
  input  logic [CNT_W-1:0]               mono_max,
  input  logic [CNT_W-1:0]               mono_rng,
  input  logic [RUN_BINS-1:0][CNT_W-1:0] run_max,
  input  logic [RUN_BINS-1:0][CNT_W-1:0] run_rng,
  input  logic [LR_W-1:0]                long_max,
  input  logic [FRQ_W-1:0]               freq_count,
  input  logic [FRQ_W-1:0]               freq_min,
  input  logic [FRQ_W-1:0]               freq_max,
  input  logic                           bit_valid,
  output logic                           bit_ready,
  input  logic                           bit_data,
  output logic                           done,
  output logic                           pass,
  output logic                           stat_fail,
  output logic                           freq_fail,
  output logic                           long_run_fail
);

  localparam logic [CNT_W:0]   CNT_ONE = (CNT_W+1)'(1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [RTY_W-1:0] RTY_ONE = RTY_W'(1);

  ehc_state_t st_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [RTY_W-1:0] tries_q;

  logic take, last_bit, begin_go, retry_go, final_go, clear, flush;
  logic stat_bad, long_bad, freq_bad, any_bad;

  logic                           close_vld, close_val;
  logic [CNT_W-1:0]               close_len, longest, ones_cnt;
  logic [RUN_BINS-1:0][CNT_W-1:0] zero_runs, one_runs;

  assign bit_ready = (st_q == EHC_SAMPLE);
  assign take      = bit_valid && bit_ready;
  assign last_bit  = ({1'b0, bit_cnt_q} + CNT_ONE) >= {1'b0, sample_len};
  assign flush     = (st_q == EHC_FLUSH);
  assign any_bad   = stat_bad || long_bad || freq_bad;
  assign begin_go  = (st_q == EHC_IDLE) && start;
  assign retry_go  = (st_q == EHC_EVAL) && any_bad && (tries_q < retry_limit);
  assign final_go  = (st_q == EHC_EVAL) && !retry_go;
  assign clear     = begin_go || retry_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= EHC_IDLE;
      bit_cnt_q <= '0;
      tries_q   <= '0;
    end else begin
      unique case (st_q)
        EHC_IDLE: begin
          if (start) begin
            st_q      <= EHC_SAMPLE;
            bit_cnt_q <= '0;
            tries_q   <= '0;
          end
        end
        EHC_SAMPLE: begin
          if (take) begin
            if (bit_cnt_q != CNT_TOP) bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            if (last_bit) st_q <= EHC_FLUSH;
          end
        end
        EHC_FLUSH: st_q <= EHC_EVAL;
        EHC_EVAL: begin
          if (retry_go) begin
            st_q      <= EHC_SAMPLE;
            bit_cnt_q <= '0;
            tries_q   <= tries_q + RTY_ONE;
          end else begin
            st_q <= EHC_IDLE;
          end
        end
        default: st_q <= EHC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done          <= 1'b0;
      pass          <= 1'b0;
      stat_fail     <= 1'b0;
      freq_fail     <= 1'b0;
      long_run_fail <= 1'b0;
    end else begin
      done <= final_go;
      if (begin_go) begin
        pass          <= 1'b0;
        stat_fail     <= 1'b0;
        freq_fail     <= 1'b0;
        long_run_fail <= 1'b0;
      end else if (final_go) begin
        pass          <= !any_bad;
        stat_fail     <= stat_bad;
        freq_fail     <= freq_bad;
        long_run_fail <= long_bad;
      end
    end
  end

  ehc_run_tracker #(.CNT_W(CNT_W)) u_runs (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .take      (take),
    .bit_in    (bit_data),
    .flush     (flush),
    .close_vld (close_vld),
    .close_val (close_val),
    .close_len (close_len),
    .longest   (longest)
  );

  ehc_tally #(.CNT_W(CNT_W), .RUN_BINS(RUN_BINS)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .take      (take),
    .bit_in    (bit_data),
    .close_vld (close_vld),
    .close_val (close_val),
    .close_len (close_len),
    .ones_cnt  (ones_cnt),
    .zero_runs (zero_runs),
    .one_runs  (one_runs)
  );

  ehc_verdict #(
    .CNT_W(CNT_W), .RUN_BINS(RUN_BINS), .LR_W(LR_W), .FRQ_W(FRQ_W)
  ) u_verdict (
    .self_test_off (self_test_off),
    .ones_cnt      (ones_cnt),
    .zero_runs     (zero_runs),
    .one_runs      (one_runs),
    .longest       (longest),
    .mono_max      (mono_max),
    .mono_rng      (mono_rng),
    .run_max       (run_max),
    .run_rng       (run_rng),
    .long_max      (long_max),
    .freq_count    (freq_count),
    .freq_min      (freq_min),
    .freq_max      (freq_max),
    .stat_bad      (stat_bad),
    .long_bad      (long_bad),
    .freq_bad      (freq_bad)
  );

endmodule

// File: rtl/ehc_checks.sv
module ehc_checks #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned FRQ_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             self_test_off,
  input logic [FRQ_W-1:0] freq_count,
  input logic [FRQ_W-1:0] freq_min,
  input logic [FRQ_W-1:0] freq_max,
  input logic             bit_ready,
  input logic             done,
  input logic             pass,
  input logic             stat_fail,
  input logic             freq_fail,
  input logic             long_run_fail,
  input logic [CNT_W-1:0] ones_cnt,
  input logic [CNT_W-1:0] bit_cnt_q
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_PASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass == !(stat_fail || freq_fail || long_run_fail))); // R9

  AST_FREQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (freq_fail == (($past(freq_count) < $past(freq_min)) ||
                            ($past(freq_count) > $past(freq_max))))); // R6

  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(self_test_off)) |-> (!stat_fail && !long_run_fail)); // R8

  AST_NO_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bit_ready); // R1

  AST_ONES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ones_cnt <= bit_cnt_q); // R2

endmodule

bind ent_health_chk ehc_checks #(.CNT_W(CNT_W), .FRQ_W(FRQ_W)) u_ehc_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .self_test_off (self_test_off),
  .freq_count    (freq_count),
  .freq_min      (freq_min),
  .freq_max      (freq_max),
  .bit_ready     (bit_ready),
  .done          (done),
  .pass          (pass),
  .stat_fail     (stat_fail),
  .freq_fail     (freq_fail),
  .long_run_fail (long_run_fail),
  .ones_cnt      (ones_cnt),
  .bit_cnt_q     (bit_cnt_q)
);

// File: tb/test_ent_health_chk.sv
module test_ent_health_chk;
  import ehc_pkg::*;

  localparam int CNT_W = EHC_CNT_W;
  localparam int RUN_BINS = EHC_RUN_BINS;
  localparam int LR_W = EHC_LR_W;
  localparam int FRQ_W = EHC_FRQ_W;
  localparam int RTY_W = EHC_RTY_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic self_test_off = 1'b0;
  logic [CNT_W-1:0] sample_len;
  logic [RTY_W-1:0] retry_limit;
  logic [CNT_W-1:0] mono_max, mono_rng;
  logic [RUN_BINS-1:0][CNT_W-1:0] run_max, run_rng;
  logic [LR_W-1:0] long_max;
  logic [FRQ_W-1:0] freq_count, freq_min, freq_max;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready, done, pass, stat_fail, freq_fail, long_run_fail;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ent_health_chk i_ent_health_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .self_test_off(self_test_off),
    .sample_len(sample_len), .retry_limit(retry_limit),
    .mono_max(mono_max), .mono_rng(mono_rng), .run_max(run_max), .run_rng(run_rng),
    .long_max(long_max), .freq_count(freq_count), .freq_min(freq_min),
    .freq_max(freq_max), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_data(bit_data), .done(done), .pass(pass), .stat_fail(stat_fail),
    .freq_fail(freq_fail), .long_run_fail(long_run_fail)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic defaults();
    self_test_off = 1'b0;
    sample_len  = CNT_W'(12);
    retry_limit = '0;
    mono_max = '0; mono_rng = '0;
    run_max = '0; run_rng = '0;
    long_max = LR_W'(255);
    freq_count = FRQ_W'(50000);
    freq_min = FRQ_W'(EHC_DEF_FMIN);
    freq_max = FRQ_W'(EHC_DEF_FMAX);
  endtask

  // Start, feed up to n bits (bit i = v[i]), then check count, timing and verdict.
  task automatic run_window(input string req, input logic [63:0] v, input int n,
                            input bit gap, input int exp_taken, input bit e_pass,
                            input bit e_stat, input bit e_freq, input bit e_long);
    int taken = 0;
    int lat = -1;
    int dn = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({req, " R9"}, "flags cleared by start",
          {pass, stat_fail, freq_fail, long_run_fail}, 0);
    for (int i = 0; i < n; i++) begin
      int w = 0;
      if (gap) begin
        bit_valid = 1'b0; bit_data = ~v[i];
        @(negedge clk);
      end
      bit_valid = 1'b1; bit_data = v[i];
      while (!bit_ready && w < 8) begin
        if (done) dn++;
        @(negedge clk); w++;
      end
      if (!bit_ready) break;
      @(negedge clk);
      taken++;
    end
    bit_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (done) begin
        if (lat < 0) lat = k;
        dn++;
      end
      @(negedge clk);
    end
    check(req, "bits taken", taken, exp_taken);
    check({req, " R9"}, "done latency", lat, 2);
    check({req, " R9"}, "done pulses", dn, 1);
    check(req, "pass", pass, e_pass);
    check(req, "stat_fail", stat_fail, e_stat);
    check(req, "freq_fail", freq_fail, e_freq);
    check(req, "long_run_fail", long_run_fail, e_long);
  endtask

  task automatic t_reset();
    check("R10", "outputs after reset",
          {done, pass, stat_fail, freq_fail, long_run_fail, bit_ready}, 0);
  endtask

  task automatic t_monobit();
    defaults();
    mono_max = 7; mono_rng = 2;              // R2: band [5,7], 6 ones
    run_window("R2 in band", 64'h555, 12, 0, 12, 1, 0, 0, 0);
    mono_max = 10; mono_rng = 2;             // R2: band [8,10]
    run_window("R2 below band", 64'h555, 12, 0, 12, 0, 1, 0, 0);
    mono_max = 6; mono_rng = 0;              // R2: upper bound inclusive
    run_window("R2 exact bound", 64'h555, 12, 0, 12, 1, 0, 0, 0);
  endtask

  task automatic t_retry();
    defaults();
    mono_max = 10; mono_rng = 2; retry_limit = 2;
    run_window("R7 exhausted", 64'h5_5555_5555, 36, 0, 36, 0, 1, 0, 0);
    mono_max = 7; mono_rng = 2;
    run_window("R7 recovers", 64'h555_000, 24, 0, 24, 1, 0, 0, 0);
  endtask

  task automatic t_runs();
    defaults();
    run_max[0] = 6; run_rng[0] = 0;          // R3: six length-1 runs each polarity
    run_window("R3 len1 pass", 64'h555, 12, 0, 12, 1, 0, 0, 0);
    run_max[0] = 5; run_rng[0] = 1;
    run_window("R3 len1 fail", 64'h555, 12, 0, 12, 0, 1, 0, 0);
    defaults();
    run_max[4] = 1; run_rng[4] = 0;          // R3: last run closed by window end
    run_window("R3 end close", 64'h07C, 12, 0, 12, 1, 0, 0, 0);
    defaults();
    run_max[5] = 1; run_rng[5] = 0;          // R3: length 6 lands in the tail bin
    run_window("R3 tail bin", 64'hFC0, 12, 0, 12, 1, 0, 0, 0);
    run_max[5] = 2; run_rng[5] = 0;
    run_window("R3 tail fail", 64'hFC0, 12, 0, 12, 0, 1, 0, 0);
  endtask

  task automatic t_band_rules();
    defaults();
    mono_max = 8; mono_rng = 20;             // R4: lower bound clamps to 0
    run_window("R4 clamp", 64'h000, 12, 0, 12, 1, 0, 0, 0);
    run_window("R4 disabled", 64'hFFF, 12, 0, 12, 0, 1, 0, 0);
    mono_max = 0; mono_rng = 0;              // R4: zero band always passes
    run_window("R4 zero band", 64'hFFF, 12, 0, 12, 1, 0, 0, 0);
  endtask

  task automatic t_long_run();
    defaults();
    long_max = 5;
    run_window("R5 too long", 64'hFC0, 12, 0, 12, 0, 0, 0, 1);
    long_max = 6;
    run_window("R5 at limit", 64'hFC0, 12, 0, 12, 1, 0, 0, 0);
  endtask

  task automatic t_freq();
    defaults();
    freq_count = 29999;
    run_window("R6 below", 64'h555, 12, 0, 12, 0, 0, 1, 0);
    freq_count = 30000;
    run_window("R6 min edge", 64'h555, 12, 0, 12, 1, 0, 0, 0);
    freq_count = 75000;
    run_window("R6 max edge", 64'h555, 12, 0, 12, 1, 0, 0, 0);
    freq_count = 75001;
    run_window("R6 above", 64'h555, 12, 0, 12, 0, 0, 1, 0);
  endtask

  task automatic t_bypass();
    defaults();
    self_test_off = 1'b1;
    mono_max = 10; mono_rng = 2; long_max = 0;
    run_window("R8 bypass", 64'h555, 12, 0, 12, 1, 0, 0, 0);
    freq_count = 80000;
    run_window("R8 freq kept", 64'h555, 12, 0, 12, 0, 0, 1, 0);
  endtask

  task automatic t_handshake();
    defaults();
    mono_max = 6; mono_rng = 0;
    bit_valid = 1'b1; bit_data = 1'b1;       // R1: offered while idle
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1", "ready low in idle", bit_ready, 0);
    end
    bit_valid = 1'b0;
    run_window("R1 gaps", 64'h555, 12, 1, 12, 1, 0, 0, 0);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_monobit();
    t_retry();
    t_runs();
    t_band_rules();
    t_long_run();
    t_freq();
    t_bypass();
    t_handshake();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule